// File: doc/BRIEF.md
# Coprocessor Escape Instruction Gatekeeper

This block sits between the instruction decoder and an attached numeric coprocessor. The decoder presents the first byte of each decoded instruction. The block recognises two kinds of instruction. Escape instructions are the ones meant for the coprocessor. The WAIT instruction makes the CPU wait on the coprocessor. For either kind, the block returns exactly one verdict one cycle later: hand the instruction to the coprocessor, raise the coprocessor-not-available trap (vector 7), or raise the coprocessor-error trap (vector 16).

The verdict depends on three flags held in a small machine status word:

- monitor coprocessor,
- emulate coprocessor,
- task switched.

It also depends on the coprocessor error input, sampled in the decode cycle. The status word can be read at any privilege level. It can be loaded only at privilege level 0. A load from any other level is refused and reported as a protection fault. A load that would set both the emulation and monitor flags is refused and reported as an illegal configuration. The software emulation code, instruction fetch and the coprocessor itself lie outside the block.

Top module: `copro_escape_gate`

## Requirements
- R1: An opcode byte whose upper five bits are 11011 is an escape instruction, and the byte 0x9B is WAIT. A decoded byte of any other value produces no verdict pulse.
- R2: Each decoded escape or WAIT instruction produces exactly one of `copro_fwd`, `trap_unavail` or `trap_copro_err`. That output is high for the single cycle after the decode cycle.
- R3: An escape decoded while the emulation flag is set gives `trap_unavail` and is not forwarded. This check has the highest priority.
- R4: An escape decoded with emulation clear and task-switched set gives `trap_unavail`. A WAIT decoded with both task-switched and monitor set also gives `trap_unavail`.
- R5: An escape that passes the R3 and R4 checks, has `dec_err_check` high, and sees `copro_error` high in the decode cycle gives `trap_copro_err`. With `dec_err_check` low, the error input is ignored and the escape is forwarded.
- R6: A WAIT that passes the R4 check gives `trap_copro_err` when `copro_error` is high and emulation is clear. While emulation is set, the error input is ignored and the WAIT is forwarded.
- R7: A load at privilege 0 that does not set both bit 1 and bit 2 stores the flags from the load data: bit 1 is monitor, bit 2 is emulation, bit 3 is task-switched. The new value appears on `msw_rdata` from the next cycle. All other bits of `msw_rdata` read 0. A verdict decided in the same cycle as a load uses the flag values from before the load.
- R8: A load at privilege 1, 2 or 3 leaves the flags unchanged and pulses `prot_fault` for the next cycle.
- R9: A load at privilege 0 that sets both bit 1 and bit 2 leaves the flags unchanged and pulses `cfg_illegal` for the next cycle.
- R10: After reset, all flags are 0 and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | A decoded instruction is present this cycle |
| dec_opcode | input | 8 | First byte of the decoded instruction |
| dec_err_check | input | 1 | This escape is one that must sample the error input |
| copro_error | input | 1 | Coprocessor error indication, high = error pending |
| cur_pl | input | 2 | Current privilege level, 0 = most privileged |
| msw_load | input | 1 | Request to load the machine status word |
| msw_load_data | input | 16 | Value to load |
| msw_rdata | output | 16 | Current machine status word |
| copro_fwd | output | 1 | Pulse: forward the instruction to the coprocessor |
| trap_unavail | output | 1 | Pulse: coprocessor-not-available trap (vector 7) |
| trap_copro_err | output | 1 | Pulse: coprocessor-error trap (vector 16) |
| prot_fault | output | 1 | Pulse: status word load refused for privilege |
| cfg_illegal | output | 1 | Pulse: status word load refused, emulation and monitor both set |

## Verification
Random opcodes are weighted toward escape bytes and WAIT, with some arbitrary bytes mixed in. They are paired with random flag loads, error levels and privilege levels. This exercises every ordering of the emulation, task-switched and error checks, and the cases where escape and WAIT handling diverge. Directed cases cover the following:

- opcode bytes at both edges of the escape range, 0xD8 and 0xDF;
- neighbour bytes 0xD7 and 0xE0, which must stay silent;
- WAIT with emulation set and the error input high, which separates the WAIT error skip from the escape error path;
- a load and a decode in the same cycle, which shows that verdicts use the flags from before the load;
- refused loads, where the flags are read back to confirm they did not change.

// File: rtl/copro_gate_pkg.sv
// Package: copro_gate_pkg
// Shared types for the coprocessor escape gatekeeper.
// Assumes: one verdict per decoded instruction; flags are held as a packed struct.
package copro_gate_pkg;

    typedef enum logic [1:0] {
        VERDICT_NONE    = 2'd0,
        VERDICT_FORWARD = 2'd1,
        VERDICT_UNAVAIL = 2'd2,
        VERDICT_ERROR   = 2'd3
    } verdict_e;

    typedef struct packed {
        logic ts;   // task switched
        logic em;   // emulate coprocessor
        logic mp;   // monitor coprocessor
    } copro_flags_t;

endpackage

// File: rtl/copro_op_classify.sv
// Module: copro_op_classify
// Purely combinational sorting of a first instruction byte into escape, WAIT or other.
// Assumes: the byte is only meaningful when the decoder marks it valid.
module copro_op_classify #(
    parameter int          OP_W        = 8,
    parameter int          PREFIX_W    = 5,
    parameter logic [4:0]  ESC_PREFIX  = 5'b11011,
    parameter logic [7:0]  WAIT_OPCODE = 8'h9B
) (
    input  logic [OP_W-1:0] opcode,
    output logic            is_esc,
    output logic            is_wait
);
    localparam int PREFIX_LSB = OP_W - PREFIX_W;

    // Compare the upper field with the escape prefix and the whole byte with WAIT.
    always_comb begin
        is_esc  = (opcode[OP_W-1:PREFIX_LSB] == ESC_PREFIX[PREFIX_W-1:0]);
        is_wait = (opcode == WAIT_OPCODE[OP_W-1:0]);
    end

endmodule

// File: rtl/copro_msw_reg.sv
// Module: copro_msw_reg
// Holds the monitor, emulation and task-switched flags of the machine status word.
// Loads are accepted only at privilege 0 and only when emulation and monitor are not both requested.
// A refused load raises a one-cycle fault pulse.
// Assumes: privilege 0 is the most privileged; reads are allowed at any level.
module copro_msw_reg
    import copro_gate_pkg::*;
#(
    parameter int MSW_W  = 16,
    parameter int PL_W   = 2,
    parameter int MP_BIT = 1,
    parameter int EM_BIT = 2,
    parameter int TS_BIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [MSW_W-1:0] load_data,
    input  logic [PL_W-1:0]  cur_pl,
    output copro_flags_t     flags,
    output logic [MSW_W-1:0] rdata,
    output logic             prot_fault,
    output logic             cfg_illegal
);
    logic privileged;
    logic both_set;
    logic unused_load_bits;

    // Decode the privilege and configuration checks for the load.
    always_comb begin
        privileged       = (cur_pl == '0);
        both_set         = load_data[EM_BIT] && load_data[MP_BIT];
        unused_load_bits = ^load_data;
    end

    // Update the flags and the refusal pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags       <= '0;
            prot_fault  <= 1'b0;
            cfg_illegal <= 1'b0;
        end else begin
            prot_fault  <= 1'b0;
            cfg_illegal <= 1'b0;
            if (load) begin
                if (!privileged) begin
                    prot_fault <= 1'b1;
                end else if (both_set) begin
                    cfg_illegal <= 1'b1;
                end else begin
                    flags.mp <= load_data[MP_BIT];
                    flags.em <= load_data[EM_BIT];
                    flags.ts <= load_data[TS_BIT];
                end
            end
        end
    end

    // Place the flags at their bit positions; unused bits read zero.
    always_comb begin
        rdata         = '0;
        rdata[MP_BIT] = flags.mp;
        rdata[EM_BIT] = flags.em;
        rdata[TS_BIT] = flags.ts;
    end

    AST_LOAD_PRIV_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !privileged) |=> (flags == $past(flags)) && prot_fault) else $error("AST_LOAD_PRIV_KEEPS"); // R8
    AST_BOTH_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (load && privileged && both_set) |=> (flags == $past(flags)) && cfg_illegal) else $error("AST_BOTH_REFUSED"); // R9
    AST_NEVER_EM_MP: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags.em && flags.mp)) else $error("AST_NEVER_EM_MP"); // R9

endmodule

// File: rtl/copro_verdict.sv
// Module: copro_verdict
// Chooses forward, not-available trap or error trap for a decoded escape or WAIT.
// The verdict is registered as a one-cycle pulse.
// Assumes: flags are the values held before any load in the same cycle,
// and the error input is sampled only in the decode cycle.
module copro_verdict
    import copro_gate_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dec_valid,
    input  logic         is_esc,
    input  logic         is_wait,
    input  logic         err_check,
    input  logic         copro_error,
    input  copro_flags_t flags,
    output logic         fwd,
    output logic         trap_unavail,
    output logic         trap_err
);
    verdict_e decision;

    // Apply the checks in priority order: emulation, task switch, error.
    always_comb begin
        decision = VERDICT_NONE;
        if (dec_valid && is_esc) begin
            if (flags.em)                     decision = VERDICT_UNAVAIL;
            else if (flags.ts)                decision = VERDICT_UNAVAIL;
            else if (err_check && copro_error) decision = VERDICT_ERROR;
            else                              decision = VERDICT_FORWARD;
        end else if (dec_valid && is_wait) begin
            if (flags.ts && flags.mp)         decision = VERDICT_UNAVAIL;
            else if (!flags.em && copro_error) decision = VERDICT_ERROR;
            else                              decision = VERDICT_FORWARD;
        end
    end

    // Turn the decision into one registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd          <= 1'b0;
            trap_unavail <= 1'b0;
            trap_err     <= 1'b0;
        end else begin
            fwd          <= (decision == VERDICT_FORWARD);
            trap_unavail <= (decision == VERDICT_UNAVAIL);
            trap_err     <= (decision == VERDICT_ERROR);
        end
    end

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (is_esc || is_wait)) |=> $countones({fwd, trap_unavail, trap_err}) == 1) else $error("AST_ONE_VERDICT"); // R2
    AST_SILENT_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_valid && (is_esc || is_wait)) |=> !(fwd || trap_unavail || trap_err)) else $error("AST_SILENT_OTHER"); // R1
    AST_EM_BLOCKS_ESC: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && is_esc && flags.em) |=> trap_unavail && !fwd) else $error("AST_EM_BLOCKS_ESC"); // R3
    AST_WAIT_EM_SKIPS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && is_wait && flags.em && !flags.ts) |=> fwd) else $error("AST_WAIT_EM_SKIPS_ERR"); // R6

endmodule

// File: rtl/copro_escape_gate.sv
// Module: copro_escape_gate
// Top of the coprocessor escape gatekeeper.
// It classifies the decoded opcode, holds the machine status word,
// and issues one verdict pulse per escape or WAIT instruction.
// Assumes: the decoder asserts dec_err_check for the escapes that must sample the error input.
module copro_escape_gate
    import copro_gate_pkg::*;
#(
    parameter int         OP_W        = 8,
    parameter int         MSW_W       = 16,
    parameter int         PL_W        = 2,
    parameter int         MP_BIT      = 1,
    parameter int         EM_BIT      = 2,
    parameter int         TS_BIT      = 3,
    parameter logic [4:0] ESC_PREFIX  = 5'b11011,
    parameter logic [7:0] WAIT_OPCODE = 8'h9B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [OP_W-1:0]  dec_opcode,
    input  logic             dec_err_check,
    input  logic             copro_error,
    input  logic [PL_W-1:0]  cur_pl,
    input  logic             msw_load,
    input  logic [MSW_W-1:0] msw_load_data,
    output logic [MSW_W-1:0] msw_rdata,
    output logic             copro_fwd,
    output logic             trap_unavail,
    output logic             trap_copro_err,
    output logic             prot_fault,
    output logic             cfg_illegal
);
    localparam int PREFIX_W = 5;

    logic         is_esc;
    logic         is_wait;
    copro_flags_t flags;

    copro_op_classify #(
        .OP_W(OP_W), .PREFIX_W(PREFIX_W),
        .ESC_PREFIX(ESC_PREFIX), .WAIT_OPCODE(WAIT_OPCODE)
    ) classify_i (
        .opcode(dec_opcode), .is_esc(is_esc), .is_wait(is_wait)
    );

    copro_msw_reg #(
        .MSW_W(MSW_W), .PL_W(PL_W),
        .MP_BIT(MP_BIT), .EM_BIT(EM_BIT), .TS_BIT(TS_BIT)
    ) msw_i (
        .clk(clk), .rst_n(rst_n), .load(msw_load), .load_data(msw_load_data),
        .cur_pl(cur_pl), .flags(flags), .rdata(msw_rdata),
        .prot_fault(prot_fault), .cfg_illegal(cfg_illegal)
    );

    copro_verdict verdict_i (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
        .is_esc(is_esc), .is_wait(is_wait), .err_check(dec_err_check),
        .copro_error(copro_error), .flags(flags),
        .fwd(copro_fwd), .trap_unavail(trap_unavail), .trap_err(trap_copro_err)
    );

endmodule

// File: tb/copro_escape_gate_tb.sv
`timescale 1ns/1ps
module copro_escape_gate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [7:0]  dec_opcode = '0;
    logic        dec_err_check = 1'b0;
    logic        copro_error = 1'b0;
    logic [1:0]  cur_pl = '0;
    logic        msw_load = 1'b0;
    logic [15:0] msw_load_data = '0;
    logic [15:0] msw_rdata;
    logic        copro_fwd, trap_unavail, trap_copro_err, prot_fault, cfg_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic m_mp = 1'b0, m_em = 1'b0, m_ts = 1'b0;

    always #4 clk = ~clk;

    copro_escape_gate dut_i (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_opcode(dec_opcode),
        .dec_err_check(dec_err_check), .copro_error(copro_error), .cur_pl(cur_pl),
        .msw_load(msw_load), .msw_load_data(msw_load_data), .msw_rdata(msw_rdata),
        .copro_fwd(copro_fwd), .trap_unavail(trap_unavail), .trap_copro_err(trap_copro_err),
        .prot_fault(prot_fault), .cfg_illegal(cfg_illegal)
    );

    // Expected {fwd, unavail, err} from the requirements.
    function automatic logic [2:0] exp_verdict(logic v, logic [7:0] op, logic chk, logic er,
                                               logic mp, logic em, logic ts);
        if (!v) return 3'b000;
        if (op[7:3] == 5'b11011) begin
            if (em || ts) return 3'b010;
            if (chk && er) return 3'b001;
            return 3'b100;
        end
        if (op == 8'h9B) begin
            if (ts && mp) return 3'b010;
            if (!em && er) return 3'b001;
            return 3'b100;
        end
        return 3'b000;
    endfunction

    // Requirement tag for a verdict check.
    function automatic string verdict_tag(logic v, logic [7:0] op, logic er,
                                          logic mp, logic em, logic ts);
        if (!v || !(op[7:3] == 5'b11011 || op == 8'h9B)) return "R1";
        if (op[7:3] == 5'b11011) begin
            if (em) return "R3/R2";
            if (ts) return "R4/R2";
            return "R5/R2";
        end
        if (ts && mp) return "R4/R2";
        if (em && er) return "R6 wait skips error";
        return "R6/R2";
    endfunction

    function automatic logic [15:0] exp_rdata(logic mp, logic em, logic ts);
        return {12'b0, ts, em, mp, 1'b0};
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One cycle: drive inputs, predict, clock, sample after the edge, update the model.
    task automatic step(logic v, logic [7:0] op, logic chk, logic er,
                        logic ld, logic [1:0] pl, logic [15:0] data);
        logic [2:0] ev;
        logic       epf, eci, accept;
        string      ltag;
        dec_valid = v; dec_opcode = op; dec_err_check = chk; copro_error = er;
        msw_load = ld; cur_pl = pl; msw_load_data = data;
        ev     = exp_verdict(v, op, chk, er, m_mp, m_em, m_ts);
        epf    = ld && (pl != 2'd0);
        eci    = ld && (pl == 2'd0) && data[2] && data[1];
        accept = ld && !epf && !eci;
        ltag   = epf ? "R8" : (eci ? "R9" : "R7");
        @(posedge clk);
        #1;
        check(verdict_tag(v, op, er, m_mp, m_em, m_ts),
              {29'b0, copro_fwd, trap_unavail, trap_copro_err}, {29'b0, ev});
        if (accept) begin
            m_mp = data[1]; m_em = data[2]; m_ts = data[3];
        end
        check(ltag, {30'b0, prot_fault, cfg_illegal}, {30'b0, epf, eci});
        check(ltag, {16'b0, msw_rdata}, {16'b0, exp_rdata(m_mp, m_em, m_ts)});
        dec_valid = 1'b0; msw_load = 1'b0;
    endtask

    task automatic load(logic [1:0] pl, logic [15:0] data);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, pl, data);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R10: reset state
        check("R10", {16'b0, msw_rdata}, 32'h0);
        check("R10", {27'b0, copro_fwd, trap_unavail, trap_copro_err, prot_fault, cfg_illegal}, 32'h0);

        // R1 boundaries of the escape range and neighbours
        step(1'b1, 8'hD8, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0);
        step(1'b1, 8'hDF, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0);
        step(1'b1, 8'hD7, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0);
        step(1'b1, 8'hE0, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0);
        // R5 error on checking escape versus non-checking escape
        step(1'b1, 8'hD9, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0);
        step(1'b1, 8'hD9, 1'b0, 1'b1, 1'b0, 2'd0, 16'h0);
        // R6 WAIT with error, emulation clear
        step(1'b1, 8'h9B, 1'b0, 1'b1, 1'b0, 2'd0, 16'h0);
        // R7 set emulation; R3 escape traps; R6 WAIT skips error
        load(2'd0, 16'h0004);
        step(1'b1, 8'hDB, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0);
        step(1'b1, 8'h9B, 1'b0, 1'b1, 1'b0, 2'd0, 16'h0);
        // R8 refused load from privilege 3
        load(2'd3, 16'h0000);
        // R9 both flags refused
        load(2'd0, 16'h0006);
        // R4 task-switched with monitor: escape and WAIT trap
        load(2'd0, 16'h000A);
        step(1'b1, 8'hDD, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0);
        step(1'b1, 8'h9B, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0);
        // R7 decode and load in the same cycle use the pre-load flags
        step(1'b1, 8'hDC, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0000);
        step(1'b1, 8'hDC, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0);

        // Constrained random mix with a fixed seed
        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] op;
            int sel;
            sel = $urandom_range(0, 9);
            if (sel < 4)      op = {5'b11011, 3'($urandom_range(0, 7))};
            else if (sel < 6) op = 8'h9B;
            else              op = 8'($urandom);
            step(1'($urandom_range(0, 3) != 0), op, 1'($urandom), 1'($urandom),
                 1'($urandom_range(0, 4) == 0), 2'($urandom_range(0, 3) == 0 ? $urandom_range(1, 3) : 0),
                 16'($urandom));
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule